// File: doc/BRIEF.md
# PWM Output Steering Unit

This block routes a single PWM waveform to any chosen subset of four output pins. Every pin has its own steering enable. A pin with its enable set drives the PWM waveform. A pin with its enable clear drives its ordinary port data bit. All four pins are registered, so the outputs do not glitch when the steering changes.

Software loads a new steering mask and a timing-mode bit with one write strobe. In immediate mode the mask is applied right after the write. A pulse that is in progress can therefore be cut short, which lets software pull PWM off a pin at once. In period-aligned mode the mask waits in a shadow register and is copied to the active register when the next period-start pulse arrives. As a result, only whole PWM cycles ever appear on a pin. Producing the PWM waveform, dead-band insertion and pin direction control are handled elsewhere.

Top module: `pwm_steer_unit`

## Requirements
- R1: While `rst` is high, `pin_out` is 0. Reset clears both masks and selects immediate mode, so after reset, and before any write, every pin follows its `port_data` bit.
- R2: A pin whose active steering bit is 1 outputs the `pwm_in` value sampled on the previous clock edge.
- R3: A pin whose active steering bit is 0 outputs its `port_data` bit sampled on the previous clock edge.
- R4: Mask bit i steers pin i only (bit 0 is pin A, bit 3 is pin D). Each pin selects its source independently of the other pins.
- R5: A write (`wr_en`=1) with `wr_sync`=0 that is sampled at edge k makes the active mask equal `wr_mask` at edge k, and the pins reflect it from edge k+1.
- R6: A write with `wr_sync`=1 leaves the active mask and the pins unchanged until a `period_start` pulse. When that pulse is sampled at edge j, the pending mask becomes active at edge j and shows on the pins from edge j+1.
- R7: If several `wr_sync`=1 writes arrive before one period start, the last written mask is the one applied.
- R8: If a `wr_sync`=1 write and `period_start` are sampled at the same edge, the mask written in that cycle becomes active at that edge.
- R9: A `wr_sync`=0 write replaces any mask still pending from an earlier `wr_sync`=1 write. A later `period_start` then leaves the immediately written mask in place.
- R10: In immediate mode, `period_start` pulses have no effect on the active mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | PWM waveform to be steered |
| period_start | input | 1 | One-cycle pulse at the start of each PWM period |
| wr_en | input | 1 | Write strobe for mask and mode |
| wr_mask | input | 4 | New steering mask, bit i for pin i |
| wr_sync | input | 1 | 0 = apply now, 1 = apply at next period start |
| port_data | input | 4 | General-purpose data for pins that are not steered |
| pin_out | output | 4 | Registered pin values |

## Verification
Two events can land in the same cycle: a period-aligned write and the period-start pulse that would transfer the shadow mask. The bench first leaves one mask pending. It then drives a second period-aligned write in the same cycle as `period_start`, and requires the pins to show the second mask one edge later, with no trace of the first. A related overlap is an immediate write made while a period-aligned mask is still pending. Here the bench requires that the later period start does not bring back the stale mask.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;

  localparam int unsigned STEER_PINS_DEFAULT = 4;

  typedef enum logic {
    STEER_NOW       = 1'b0,
    STEER_AT_PERIOD = 1'b1
  } steer_mode_e;

endpackage

// File: rtl/steer_mask_ctrl.sv
module steer_mask_ctrl
  import pwm_steer_pkg::*;
#(
  parameter int unsigned NUM_PINS = STEER_PINS_DEFAULT
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [NUM_PINS-1:0] wr_mask,
  input  logic                wr_sync,
  input  logic                period_start,
  output logic [NUM_PINS-1:0] active_mask
);

  logic [NUM_PINS-1:0] shadow_q, active_q;
  logic [NUM_PINS-1:0] active_d;
  steer_mode_e         mode_q;
  steer_mode_e         wr_mode;
  logic                boundary_xfer;

  assign wr_mode = steer_mode_e'(wr_sync);

  // transfer at period start when aligned mode is in force or being written
  assign boundary_xfer = period_start &&
                         ((wr_en && wr_mode == STEER_AT_PERIOD) ||
                          (!wr_en && mode_q == STEER_AT_PERIOD));

  always_comb begin
    active_d = active_q;
    if (wr_en && wr_mode == STEER_NOW) begin
      active_d = wr_mask;
    end else if (boundary_xfer) begin
      active_d = wr_en ? wr_mask : shadow_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      active_q <= '0;
      mode_q   <= STEER_NOW;
    end else begin
      if (wr_en) begin
        shadow_q <= wr_mask;
        mode_q   <= wr_mode;
      end
      active_q <= active_d;
    end
  end

  assign active_mask = active_q;

  // R1
  reset_clears_mask_chk: assert property (@(posedge clk)
    $past(rst) |-> active_q == '0);

  // R5
  immediate_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_sync) |=> active_q == $past(wr_mask));

  // R6
  pending_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sync && !period_start) |=> $stable(active_q));

  // R6
  boundary_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (period_start && !wr_en && mode_q == STEER_AT_PERIOD)
      |=> active_q == $past(shadow_q));

  // R8
  same_cycle_write_chk: assert property (@(posedge clk) disable iff (rst)
    (period_start && wr_en && wr_sync) |=> active_q == $past(wr_mask));

  // R10
  now_mode_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && mode_q == STEER_NOW) |=> $stable(active_q));

endmodule

// File: rtl/steer_pin_cell.sv
module steer_pin_cell (
  input  logic clk,
  input  logic rst,
  input  logic steer_on,
  input  logic pwm_in,
  input  logic port_bit,
  output logic pin_q
);

  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b0;
    else     pin_q <= steer_on ? pwm_in : port_bit;
  end

  // R2
  pwm_follow_chk: assert property (@(posedge clk) disable iff (rst)
    steer_on |=> pin_q == $past(pwm_in));

  // R3
  port_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !steer_on |=> pin_q == $past(port_bit));

endmodule

// File: rtl/pwm_steer_unit.sv
module pwm_steer_unit
  import pwm_steer_pkg::*;
#(
  parameter int unsigned NUM_PINS = STEER_PINS_DEFAULT
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pwm_in,
  input  logic                period_start,
  input  logic                wr_en,
  input  logic [NUM_PINS-1:0] wr_mask,
  input  logic                wr_sync,
  input  logic [NUM_PINS-1:0] port_data,
  output logic [NUM_PINS-1:0] pin_out
);

  logic [NUM_PINS-1:0] active_mask;

  steer_mask_ctrl #(.NUM_PINS(NUM_PINS)) u_mask (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_mask      (wr_mask),
    .wr_sync      (wr_sync),
    .period_start (period_start),
    .active_mask  (active_mask)
  );

  // R4: one independent cell per pin
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    steer_pin_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .steer_on (active_mask[i]),
      .pwm_in   (pwm_in),
      .port_bit (port_data[i]),
      .pin_q    (pin_out[i])
    );
  end

  // R1
  reset_output_low_chk: assert property (@(posedge clk)
    rst |=> pin_out == '0);

endmodule

// File: tb/pwm_steer_unit_tb.sv
module pwm_steer_unit_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwm_in = 1'b0;
  logic       period_start = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_mask = '0;
  logic       wr_sync = 1'b0;
  logic [3:0] port_data = '0;
  logic [3:0] pin_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm_steer_unit u_dut (
    .clk(clk), .rst(rst), .pwm_in(pwm_in), .period_start(period_start),
    .wr_en(wr_en), .wr_mask(wr_mask), .wr_sync(wr_sync),
    .port_data(port_data), .pin_out(pin_out)
  );

  // vector: {mask[3:0], pwm, port[3:0], expected[3:0]}
  localparam int NVEC = 8;
  localparam logic [12:0] VEC [NVEC] = '{
    {4'b0000, 1'b1, 4'b1010, 4'b1010},
    {4'b1111, 1'b1, 4'b0000, 4'b1111},
    {4'b1111, 1'b0, 4'b1111, 4'b0000},
    {4'b0101, 1'b1, 4'b0000, 4'b0101},
    {4'b0101, 1'b0, 4'b1010, 4'b1010},
    {4'b1010, 1'b1, 4'b0001, 4'b1011},
    {4'b1001, 1'b0, 4'b0110, 4'b0110},
    {4'b0110, 1'b1, 4'b1001, 4'b1111}
  };

  task automatic check(input string tag, input logic [3:0] exp);
    n_run++;
    if (pin_out !== exp) begin
      n_fail++;
      $display("FAIL %s: pin_out=%b expected=%b", tag, pin_out, exp);
    end
  endtask

  // strobe one write in the current cycle; returns at next negedge
  task automatic do_write(input logic [3:0] m, input logic s, input logic ps);
    wr_en = 1'b1; wr_mask = m; wr_sync = s; period_start = ps;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; period_start = 1'b0;
  endtask

  task automatic pulse_ps();
    period_start = 1'b1;
    @(posedge clk); @(negedge clk);
    period_start = 1'b0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: pin_out=%b expected=finish", pin_out);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    port_data = 4'b1100; pwm_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 outputs low in reset", 4'b0000);
    rst = 1'b0;
    step();
    check("R1 R3 port data after reset", 4'b1100);

    // table walk, immediate mode (R2 R3 R4 R5)
    for (int i = 0; i < NVEC; i++) begin
      pwm_in = VEC[i][8]; port_data = VEC[i][7:4];
      do_write(VEC[i][12:9], 1'b0, 1'b0);
      step();
      check($sformatf("R4 R5 vector %0d", i), VEC[i][3:0]);
    end

    // R2: output tracks pwm one cycle late
    port_data = 4'b0000;
    do_write(4'b1111, 1'b0, 1'b0);
    for (int c = 0; c < 4; c++) begin
      pwm_in = c[0];
      step();
      check("R2 pwm follow", {4{c[0]}});
    end

    // R6: aligned write is pending until period start
    pwm_in = 1'b1; port_data = 4'b0000;
    do_write(4'b0000, 1'b0, 1'b0);
    do_write(4'b1111, 1'b1, 1'b0);
    step(); step();
    check("R6 pending holds", 4'b0000);
    pulse_ps();
    check("R6 boundary edge not yet", 4'b0000);
    step();
    check("R6 applied after period start", 4'b1111);

    // R7: last write in the period wins
    do_write(4'b0011, 1'b1, 1'b0);
    do_write(4'b1100, 1'b1, 1'b0);
    pulse_ps();
    step();
    check("R7 last write wins", 4'b1100);

    // R8: write coincident with period start
    do_write(4'b0001, 1'b1, 1'b0);
    do_write(4'b1000, 1'b1, 1'b1);
    step();
    check("R8 coincident write applied", 4'b1000);
    pulse_ps(); step();
    check("R8 stale mask absent", 4'b1000);

    // R9: immediate write overrides pending mask
    do_write(4'b0110, 1'b1, 1'b0);
    do_write(4'b0001, 1'b0, 1'b0);
    step();
    check("R9 immediate override", 4'b0001);
    pulse_ps(); step();
    check("R9 period start keeps override", 4'b0001);

    // R10: period start ignored in immediate mode
    port_data = 4'b1010;
    do_write(4'b0101, 1'b0, 1'b0);
    pulse_ps(); pulse_ps(); step();
    check("R10 mask unchanged", 4'b1111);
    pwm_in = 1'b0; step();
    check("R10 R4 steered pins low", 4'b1010);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule